// File: doc/BRIEF.md
# Forwarded write acceptance controller

This block sits on the write side of a bus target that forwards part of its address space to a slower back-end through a write FIFO. For every data phase of a write it decides whether to take the DWORD into the FIFO (TRDY) or to end the transfer (STOP). It may also do both at once. Writes to the target's own register space are always served. Writes to the forwarded region are refused while the back-end still owes work for an earlier, unrelated write. They are also refused when the FIFO has no room.

The controller stores the address that would follow the last accepted DWORD. When a new forwarded write opens at exactly that address, it is treated as the continuation of an earlier transfer that was cut off. That write is accepted even while the back-end is still busy. A burst that reaches the last free FIFO slot gets TRDY and STOP together on that DWORD. The FIFO storage and the back-end handshake are outside the block. The FIFO reports its fill level, and the back-end reports with a pulse when it has drained the queued writes.

Top module: `fwd_wr_accept`

## Requirements
- R1: After reset the back-end is not busy, so the first forwarded write is accepted at any address. With no open transfer, `trdy`, `stop` and `push` stay 0 even when `beat_valid` is high.
- R2: Every data phase of a register-space transfer (`txn_fwd`=0) gets `trdy`=1, `stop`=0 and `push`=0, whether or not the back-end is busy.
- R3: While the back-end is busy, a forwarded transfer that opens at any address other than the expected next address gets `stop`=1, `trdy`=0 and `push`=0 on its data phases.
- R4: A forwarded transfer that opens at the expected next address is accepted while the back-end is busy. The expected next address is the last pushed address plus 4.
- R5: When `fifo_count` equals DEPTH, a forwarded data phase gets `stop`=1, `trdy`=0 and `push`=0. This holds even for a continuation.
- R6: When `fifo_count` equals DEPTH-1, an accepted forwarded data phase gets `trdy`=1, `push`=1 and `stop`=1 in the same cycle.
- R7: A `be_drained` pulse with no push in that cycle clears the busy state. After that, a forwarded write at an unrelated address is accepted.
- R8: The k-th DWORD pushed in a transfer (k counted from 0) carries `wr_addr` = the opening address + 4*k.
- R9: Once `stop` has been given in a transfer, every later data phase of that transfer gets `stop`=1, `trdy`=0 and `push`=0 until `txn_end`.
- R10: If a push and `be_drained` fall in the same cycle, the back-end stays busy, because the new DWORD is still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Address phase of a write transfer (one cycle, never together with a data phase) |
| txn_addr | input | ADDR_W | Byte address of the first DWORD |
| txn_fwd | input | 1 | 1 = forwarded region, 0 = register space |
| beat_valid | input | 1 | Initiator presents a data DWORD this cycle |
| txn_end | input | 1 | Initiator closes the transfer |
| fifo_count | input | CNT_W | Number of DWORDs currently in the write FIFO |
| be_drained | input | 1 | Back-end has emptied all queued forwarded writes |
| trdy | output | 1 | Data phase accepted |
| stop | output | 1 | Transfer is ended by the target |
| push | output | 1 | Write the current DWORD into the FIFO |
| wr_addr | output | ADDR_W | Byte address of the DWORD being pushed |

## Verification
The critical overlap is a DWORD push and the back-end's drained pulse in the same cycle. The first would set the busy state and the second would clear it. The bench provokes this by raising `be_drained` on an accepted data phase. It then opens a forwarded write at an unrelated address, which must be refused. After a lone drained pulse, the same write must be accepted. A second overlap is a continuation and a full or nearly full FIFO at the same time. The bench judges this by whether the DWORD is taken and whether STOP comes with it.

// File: rtl/fwd_wr_accept_pkg.sv
package fwd_wr_accept_pkg;

  typedef enum logic [2:0] {
    DEC_IDLE,
    DEC_PASS,
    DEC_TAKE,
    DEC_TAKE_STOP,
    DEC_REFUSE
  } wr_dec_e;

  function automatic logic dec_trdy(input wr_dec_e d);
    return (d == DEC_PASS) || (d == DEC_TAKE) || (d == DEC_TAKE_STOP);
  endfunction

  function automatic logic dec_stop(input wr_dec_e d);
    return (d == DEC_TAKE_STOP) || (d == DEC_REFUSE);
  endfunction

  function automatic logic dec_push(input wr_dec_e d);
    return (d == DEC_TAKE) || (d == DEC_TAKE_STOP);
  endfunction

endpackage

// File: rtl/wacc_addr_track.sv
module wacc_addr_track #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [ADDR_W-1:0] open_addr,
  output logic              resume_hit
);

  function automatic logic [ADDR_W-1:0] follow(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(STEP);
  endfunction

  logic [ADDR_W-1:0] exp_q;
  logic              exp_vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q     <= '0;
      exp_vld_q <= 1'b0;
    end else if (push) begin
      exp_q     <= follow(push_addr);
      exp_vld_q <= 1'b1;
    end
  end

  assign resume_hit = exp_vld_q && (open_addr == exp_q);

endmodule

// File: rtl/wacc_busy_track.sv
module wacc_busy_track (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic drained,
  output logic busy
);

  logic busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       busy_q <= 1'b0;
    else if (push)    busy_q <= 1'b1;
    else if (drained) busy_q <= 1'b0;
  end

  assign busy = busy_q;

endmodule

// File: rtl/wacc_session.sv
module wacc_session #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open,
  input  logic [ADDR_W-1:0] open_addr,
  input  logic              open_fwd,
  input  logic              open_ok,
  input  logic              close,
  input  logic              push,
  input  logic              stop,
  output logic              active,
  output logic              is_fwd,
  output logic              admitted,
  output logic              stopped,
  output logic [ADDR_W-1:0] cur_addr
);

  function automatic logic [ADDR_W-1:0] step_up(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(STEP);
  endfunction

  logic              act_q, fwd_q, ok_q, stp_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      fwd_q  <= 1'b0;
      ok_q   <= 1'b0;
      stp_q  <= 1'b0;
      addr_q <= '0;
    end else if (open) begin
      act_q  <= 1'b1;
      fwd_q  <= open_fwd;
      ok_q   <= open_ok;
      stp_q  <= 1'b0;
      addr_q <= open_addr;
    end else begin
      if (close) act_q  <= 1'b0;
      if (stop)  stp_q  <= 1'b1;
      if (push)  addr_q <= step_up(addr_q);
    end
  end

  assign active   = act_q;
  assign is_fwd   = fwd_q;
  assign admitted = ok_q;
  assign stopped  = stp_q;
  assign cur_addr = addr_q;

endmodule

// File: rtl/wacc_decide.sv
module wacc_decide
  import fwd_wr_accept_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             beat,
  input  logic             active,
  input  logic             is_fwd,
  input  logic             admitted,
  input  logic             stopped,
  input  logic [CNT_W-1:0] fifo_count,
  output logic             full_now,
  output logic             last_slot,
  output wr_dec_e          dec
);

  assign full_now  = (fifo_count >= CNT_W'(DEPTH));
  assign last_slot = (fifo_count == CNT_W'(DEPTH - 1));

  always_comb begin
    if (!active || !beat)                 dec = DEC_IDLE;
    else if (!is_fwd)                     dec = DEC_PASS;
    else if (!admitted || stopped || full_now) dec = DEC_REFUSE;
    else if (last_slot)                   dec = DEC_TAKE_STOP;
    else                                  dec = DEC_TAKE;
  end

endmodule

// File: rtl/fwd_wr_accept.sv
module fwd_wr_accept
  import fwd_wr_accept_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  parameter int BEAT_B = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              txn_fwd,
  input  logic              beat_valid,
  input  logic              txn_end,
  input  logic [CNT_W-1:0]  fifo_count,
  input  logic              be_drained,
  output logic              trdy,
  output logic              stop,
  output logic              push,
  output logic [ADDR_W-1:0] wr_addr
);

  logic              busy_q;
  logic              resume_hit;
  logic              admit_now;
  logic              sess_active, sess_fwd, sess_ok, sess_stopped;
  logic [ADDR_W-1:0] sess_addr;
  logic              full_now, last_slot;
  wr_dec_e           dec;

  wacc_busy_track u_busy (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .drained (be_drained),
    .busy    (busy_q)
  );

  wacc_addr_track #(.ADDR_W(ADDR_W), .STEP(BEAT_B)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .push_addr  (sess_addr),
    .open_addr  (txn_addr),
    .resume_hit (resume_hit)
  );

  assign admit_now = !busy_q || resume_hit;

  wacc_session #(.ADDR_W(ADDR_W), .STEP(BEAT_B)) u_sess (
    .clk       (clk),
    .rst_n     (rst_n),
    .open      (txn_start),
    .open_addr (txn_addr),
    .open_fwd  (txn_fwd),
    .open_ok   (admit_now),
    .close     (txn_end),
    .push      (push),
    .stop      (stop),
    .active    (sess_active),
    .is_fwd    (sess_fwd),
    .admitted  (sess_ok),
    .stopped   (sess_stopped),
    .cur_addr  (sess_addr)
  );

  wacc_decide #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dec (
    .beat       (beat_valid),
    .active     (sess_active),
    .is_fwd     (sess_fwd),
    .admitted   (sess_ok),
    .stopped    (sess_stopped),
    .fifo_count (fifo_count),
    .full_now   (full_now),
    .last_slot  (last_slot),
    .dec        (dec)
  );

  assign trdy    = dec_trdy(dec);
  assign stop    = dec_stop(dec);
  assign push    = dec_push(dec);
  assign wr_addr = sess_addr;

endmodule

// File: rtl/fwd_wr_accept_chk.sv
module fwd_wr_accept_chk #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  parameter int BEAT_B = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              beat_valid,
  input logic              txn_end,
  input logic [CNT_W-1:0]  fifo_count,
  input logic              be_drained,
  input logic              trdy,
  input logic              stop,
  input logic              push,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              busy_q,
  input logic              sess_active,
  input logic              sess_fwd
);

  a_r1_quiet_without_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy || stop || push) |-> beat_valid);

  a_r2_register_served: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && sess_active && !sess_fwd) |-> (trdy && !stop && !push));

  a_r5_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (fifo_count < CNT_W'(DEPTH)));

  a_r6_last_slot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (push && fifo_count == CNT_W'(DEPTH - 1)) |-> (stop && trdy));

  a_r7_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (be_drained && !push) |=> !busy_q);

  a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (push && $past(push)) |-> (wr_addr == $past(wr_addr) + ADDR_W'(BEAT_B)));

  a_r9_stop_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !txn_end) |=> !push);

  a_r10_push_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> busy_q);

endmodule

bind fwd_wr_accept fwd_wr_accept_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .BEAT_B(BEAT_B)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .beat_valid  (beat_valid),
  .txn_end     (txn_end),
  .fifo_count  (fifo_count),
  .be_drained  (be_drained),
  .trdy        (trdy),
  .stop        (stop),
  .push        (push),
  .wr_addr     (wr_addr),
  .busy_q      (busy_q),
  .sess_active (sess_active),
  .sess_fwd    (sess_fwd)
);

// File: tb/fwd_wr_accept_tb.sv
module fwd_wr_accept_tb;

  localparam int AW    = 32;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          txn_start, txn_fwd, beat_valid, txn_end, be_drained;
  logic [AW-1:0] txn_addr;
  logic [CW-1:0] fifo_count;
  logic          trdy, stop, push;
  logic [AW-1:0] wr_addr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fwd_wr_accept #(.ADDR_W(AW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_addr(txn_addr),
    .txn_fwd(txn_fwd), .beat_valid(beat_valid), .txn_end(txn_end),
    .fifo_count(fifo_count), .be_drained(be_drained),
    .trdy(trdy), .stop(stop), .push(push), .wr_addr(wr_addr)
  );

  task automatic chk(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic open_txn(input logic [AW-1:0] a, input logic fwd);
    txn_start = 1'b1; txn_addr = a; txn_fwd = fwd;
    @(posedge clk); #1;
    txn_start = 1'b0;
  endtask

  task automatic close_txn();
    txn_end = 1'b1;
    @(posedge clk); #1;
    txn_end = 1'b0;
  endtask

  task automatic pulse_drain();
    be_drained = 1'b1;
    @(posedge clk); #1;
    be_drained = 1'b0;
  endtask

  // one data phase; sample mid-cycle, expect trdy/stop/push and address when pushing
  task automatic beat(input string req, input logic drn,
                      input logic et, input logic es, input logic ep, input logic [AW-1:0] ea);
    beat_valid = 1'b1; be_drained = drn;
    #9;
    chk({req, " trdy"}, AW'(trdy), AW'(et));
    chk({req, " stop"}, AW'(stop), AW'(es));
    chk({req, " push"}, AW'(push), AW'(ep));
    if (ep) chk({req, " wr_addr"}, wr_addr, ea);
    @(posedge clk); #1;
    beat_valid = 1'b0; be_drained = 1'b0;
  endtask

  task automatic t_reset_idle();        // R1
    beat("R1 idle", 1'b0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_first_fwd();         // R1, R8
    open_txn(32'h1000, 1'b1);
    beat("R1 first", 1'b0, 1'b1, 1'b0, 1'b1, 32'h1000);
    beat("R8 k1",    1'b0, 1'b1, 1'b0, 1'b1, 32'h1004);
    beat("R8 k2",    1'b0, 1'b1, 1'b0, 1'b1, 32'h1008);
    close_txn();
  endtask

  task automatic t_register_busy();     // R2
    open_txn(32'h40, 1'b0);
    beat("R2 reg0", 1'b0, 1'b1, 1'b0, 1'b0, '0);
    beat("R2 reg1", 1'b0, 1'b1, 1'b0, 1'b0, '0);
    close_txn();
  endtask

  task automatic t_busy_nonseq();       // R3, R9
    open_txn(32'h2000, 1'b1);
    beat("R3 refuse", 1'b0, 1'b0, 1'b1, 1'b0, '0);
    beat("R9 again",  1'b0, 1'b0, 1'b1, 1'b0, '0);
    close_txn();
  endtask

  task automatic t_resume();            // R4
    open_txn(32'h100C, 1'b1);
    beat("R4 resume", 1'b0, 1'b1, 1'b0, 1'b1, 32'h100C);
    close_txn();
  endtask

  task automatic t_full();              // R5
    fifo_count = CW'(DEPTH);
    open_txn(32'h1010, 1'b1);
    beat("R5 full", 1'b0, 1'b0, 1'b1, 1'b0, '0);
    close_txn();
  endtask

  task automatic t_last_slot();         // R6, R9
    fifo_count = CW'(DEPTH - 1);
    open_txn(32'h1010, 1'b1);
    beat("R6 last",  1'b0, 1'b1, 1'b1, 1'b1, 32'h1010);
    beat("R9 after", 1'b0, 1'b0, 1'b1, 1'b0, '0);
    close_txn();
    fifo_count = '0;
  endtask

  task automatic t_drain_then_new();    // R7, R10
    pulse_drain();
    open_txn(32'h3000, 1'b1);
    beat("R7 new",       1'b0, 1'b1, 1'b0, 1'b1, 32'h3000);
    beat("R10 overlap",  1'b1, 1'b1, 1'b0, 1'b1, 32'h3004);
    close_txn();
    open_txn(32'h5000, 1'b1);
    beat("R10 still busy", 1'b0, 1'b0, 1'b1, 1'b0, '0);
    close_txn();
    pulse_drain();
    open_txn(32'h5000, 1'b1);
    beat("R7 cleared", 1'b0, 1'b1, 1'b0, 1'b1, 32'h5000);
    close_txn();
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; txn_start = 1'b0; txn_fwd = 1'b0; txn_addr = '0;
    beat_valid = 1'b0; txn_end = 1'b0; be_drained = 1'b0; fifo_count = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset_idle();
    t_first_fwd();
    t_register_busy();
    t_busy_nonseq();
    t_resume();
    t_full();
    t_last_slot();
    t_drain_then_new();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule